// File: doc/BRIEF.md
# Multiframe Auxiliary Channel Interrupt Controller

This block sits between a line transceiver and a host. A 4-bit auxiliary code travels once per multiframe in each direction. On the receive side the block compares each code that arrives at the multiframe end strobe with the code it holds. When they differ it keeps the new code and raises a change event. On the transmit side the host writes a holding register. The block copies that register into the outgoing code at every multiframe start strobe, and at the same strobe it raises a write-window event. A host write that lands after the window opens is therefore sent in the following multiframe.

The two auxiliary-channel events share a four-bit status register with two other transceiver event sources, a loss/level-detect pulse and an indication pulse. An eight-bit mask register resets to all ones. The interrupt output is high while any status bit is set whose mask bit is clear. The host reaches the block through a single-cycle register bus. Read data is combinational and any read side effect takes place at the clock edge that ends the access.

Top module: `mf_aux_irq`

## Requirements
- R1: After reset the mask register reads 0xFF, the status register reads 0x00, the receive code and transmit holding registers read 0x00, `tx_code_o` is 0 and `irq_o` is low.
- R2: On `mf_end_i`, if `rx_code_i` differs from the held receive code, the held code takes the new value and status bit 2 (change) is set. An equal code sets nothing and leaves the held code unchanged.
- R3: A read of address 2 returns the held receive code in bits 3:0 and clears status bit 2. The held code keeps its value across reads and strobes until another differing code arrives.
- R4: Every `mf_start_i` sets status bit 3 (write window). A write to address 3 clears it.
- R5: At `mf_start_i`, `tx_code_o` takes the transmit holding register value. A code written before a strobe goes out from that strobe. A code written after the strobe goes out from the next strobe. `tx_code_o` does not change between strobes.
- R6: `irq_o` is high exactly when (status & ~mask[3:0]) is nonzero. Writing the mask never changes a status bit.
- R7: Events on different status bits in the same cycle are all recorded. When a set and a clear of the same status bit occur in the same cycle, the bit ends up set.
- R8: A `loss_evt_i` pulse sets status bit 0 and an `ind_evt_i` pulse sets status bit 1. A read of address 0 clears bits 0 and 1 and leaves bits 2 and 3 unchanged.
- R9: Address map: 0 is status (writes are ignored), 1 is the mask (read/write, 8 bits), 2 is the receive code (writes are ignored), 3 is the transmit holding register (read/write, bits 3:0). Unused read bits return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mf_start_i | input | 1 | One-cycle multiframe start strobe |
| mf_end_i | input | 1 | One-cycle multiframe end strobe, qualifies rx_code_i |
| rx_code_i | input | 4 | Received auxiliary code |
| tx_code_o | output | 4 | Auxiliary code being sent this multiframe |
| loss_evt_i | input | 1 | Loss/level-detect event pulse |
| ind_evt_i | input | 1 | Received indication event pulse |
| req_i | input | 1 | Bus access strobe, one cycle per access |
| we_i | input | 1 | 1 for a write access, 0 for a read |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the cycle of the access |
| irq_o | output | 1 | Interrupt request |

## Verification
A strobe or pulse driven in one cycle shows up in the status bits, in the held codes, in `tx_code_o` and in `irq_o` one clock edge later. The bench drives every input on a falling edge and samples the outputs at the next falling edge. Read data depends on the address through logic only, so the bench samples it 1 ns after it drives the address, before the rising edge at which the clear-on-read takes effect. The same-cycle cases drive the strobe and the bus access on the same falling edge. They then inspect the result one edge later, which covers both the set/clear collision and the data captured on the old side of the edge.

// File: rtl/mf_aux_pkg.sv
package mf_aux_pkg;
  localparam int unsigned N_SRC  = 4;
  localparam int unsigned CODE_W = 4;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_STAT = 2'd0;
  localparam logic [ADDR_W-1:0] A_MASK = 2'd1;
  localparam logic [ADDR_W-1:0] A_RXC  = 2'd2;
  localparam logic [ADDR_W-1:0] A_TXC  = 2'd3;

  localparam int unsigned S_LOSS = 0;
  localparam int unsigned S_IND  = 1;
  localparam int unsigned S_CHG  = 2;
  localparam int unsigned S_WRT  = 3;
endpackage

// File: rtl/mf_rx_tracker.sv
module mf_rx_tracker #(
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mf_end_i,
  input  logic [CODE_W-1:0] rx_code_i,
  output logic [CODE_W-1:0] code_o,
  output logic              chg_o
);
  logic [CODE_W-1:0] hold_q;

  assign chg_o  = mf_end_i && (rx_code_i != hold_q);
  assign code_o = hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hold_q <= '0;
    else if (chg_o) hold_q <= rx_code_i;
  end

  // R3
  rx_hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mf_end_i |=> $stable(hold_q));
  // R2
  rx_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mf_end_i |=> hold_q == $past(rx_code_i));
endmodule

// File: rtl/mf_tx_buffer.sv
module mf_tx_buffer #(
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mf_start_i,
  input  logic              wr_i,
  input  logic [CODE_W-1:0] wdata_i,
  output logic [CODE_W-1:0] hold_o,
  output logic [CODE_W-1:0] tx_code_o
);
  logic [CODE_W-1:0] hold_q, shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= '0;
      shift_q <= '0;
    end else begin
      if (wr_i)       hold_q  <= wdata_i;
      if (mf_start_i) shift_q <= hold_q;
    end
  end

  assign hold_o    = hold_q;
  assign tx_code_o = shift_q;

  // R5
  tx_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mf_start_i |=> $stable(shift_q));
  // R5
  tx_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mf_start_i |=> shift_q == $past(hold_q));
endmodule

// File: rtl/mf_irq_ctrl.sv
module mf_irq_ctrl #(
  parameter int unsigned N_SRC  = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  set_i,
  input  logic [N_SRC-1:0]  clr_i,
  input  logic              mask_we_i,
  input  logic [DATA_W-1:0] mask_wdata_i,
  output logic [N_SRC-1:0]  stat_o,
  output logic [DATA_W-1:0] mask_o,
  output logic              irq_o
);
  logic [N_SRC-1:0]  stat_q;
  logic [DATA_W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '1;
    else if (mask_we_i) mask_q <= mask_wdata_i;
  end

  for (genvar k = 0; k < N_SRC; k++) begin : g_src
    // set has priority so a colliding event is not lost
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       stat_q[k] <= 1'b0;
      else if (set_i[k]) stat_q[k] <= 1'b1;
      else if (clr_i[k]) stat_q[k] <= 1'b0;
    end

    // R7
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] |=> stat_q[k]);
    // R6
    stat_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_q[k] && !clr_i[k]) |=> stat_q[k]);
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign irq_o  = |(stat_q & ~mask_q[N_SRC-1:0]);
endmodule

// File: rtl/mf_aux_irq.sv
module mf_aux_irq
  import mf_aux_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mf_start_i,
  input  logic              mf_end_i,
  input  logic [CODE_W-1:0] rx_code_i,
  output logic [CODE_W-1:0] tx_code_o,
  input  logic              loss_evt_i,
  input  logic              ind_evt_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic              rd, wr;
  logic              chg;
  logic [CODE_W-1:0] rx_code, tx_hold;
  logic [N_SRC-1:0]  set_v, clr_v, stat;
  logic [DATA_W-1:0] mask;

  assign rd = req_i && !we_i;
  assign wr = req_i &&  we_i;

  mf_rx_tracker #(.CODE_W(CODE_W)) u_rx (
    .clk_i, .rst_ni, .mf_end_i, .rx_code_i,
    .code_o(rx_code), .chg_o(chg)
  );

  mf_tx_buffer #(.CODE_W(CODE_W)) u_tx (
    .clk_i, .rst_ni, .mf_start_i,
    .wr_i(wr && addr_i == A_TXC), .wdata_i(wdata_i[CODE_W-1:0]),
    .hold_o(tx_hold), .tx_code_o
  );

  always_comb begin
    set_v = '0;
    set_v[S_LOSS] = loss_evt_i;
    set_v[S_IND]  = ind_evt_i;
    set_v[S_CHG]  = chg;
    set_v[S_WRT]  = mf_start_i;
    clr_v = '0;
    clr_v[S_LOSS] = rd && addr_i == A_STAT;
    clr_v[S_IND]  = rd && addr_i == A_STAT;
    clr_v[S_CHG]  = rd && addr_i == A_RXC;
    clr_v[S_WRT]  = wr && addr_i == A_TXC;
  end

  mf_irq_ctrl #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_irq (
    .clk_i, .rst_ni, .set_i(set_v), .clr_i(clr_v),
    .mask_we_i(wr && addr_i == A_MASK), .mask_wdata_i(wdata_i),
    .stat_o(stat), .mask_o(mask), .irq_o
  );

  always_comb begin
    unique case (addr_i)
      A_STAT:  rdata_o = {{(DATA_W-N_SRC){1'b0}}, stat};
      A_MASK:  rdata_o = mask;
      A_RXC:   rdata_o = {{(DATA_W-CODE_W){1'b0}}, rx_code};
      default: rdata_o = {{(DATA_W-CODE_W){1'b0}}, tx_hold};
    endcase
  end

  // R4
  wrt_on_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mf_start_i |=> stat[S_WRT]);
  // R3
  chg_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i == A_RXC && !mf_end_i) |=> !stat[S_CHG]);
  // R8
  stat_read_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i == A_STAT && stat[S_CHG]) |=> stat[S_CHG]);
endmodule

// File: tb/mf_aux_irq_bench.sv
`timescale 1ns/1ps
module mf_aux_irq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mf_start = 0, mf_end = 0, loss = 0, ind = 0;
  logic [3:0] rxc = '0;
  logic [3:0] txc;
  logic       req = 0, we = 0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic       irq;
  int         n_cmp = 0, n_bad = 0;
  logic [7:0] d;
  logic [3:0] prev;
  bit         done = 0;

  always #2.5 clk = ~clk;

  mf_aux_irq u_mf_aux_irq (
    .clk_i(clk), .rst_ni(rst_n), .mf_start_i(mf_start), .mf_end_i(mf_end),
    .rx_code_i(rxc), .tx_code_o(txc), .loss_evt_i(loss), .ind_evt_i(ind),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_o(irq)
  );

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    mf_start = 0; mf_end = 0; loss = 0; ind = 0; req = 0; we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    req = 1; we = 0; addr = a;
    #1 v = rdata;
    tick();
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] v);
    req = 1; we = 1; addr = a; wdata = v;
    tick();
  endtask

  task automatic end_mf(input logic [3:0] c);
    mf_end = 1; rxc = c;
    tick();
  endtask

  task automatic start_mf();
    mf_start = 1;
    tick();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 tx_code", txc, 0);
    rd(2'd0, d); chk("R1 status", d, 8'h00);
    rd(2'd1, d); chk("R1 mask", d, 8'hFF);
    rd(2'd2, d); chk("R1 rx code", d, 8'h00);
    rd(2'd3, d); chk("R1 tx hold", d, 8'h00);

    // R9 writes to read-only addresses ignored
    wr(2'd0, 8'hFF); rd(2'd0, d); chk("R9 status write ignored", d, 8'h00);
    wr(2'd2, 8'h07); rd(2'd2, d); chk("R9 rx write ignored", d, 8'h00);
    wr(2'd1, 8'hA5); rd(2'd1, d); chk("R9 mask rw", d, 8'hA5);
    wr(2'd1, 8'hFF);

    // R2 / R3 sweep: each code twice, change only on first when differing
    prev = 4'd0;
    for (int v = 0; v < 16; v++) begin
      for (int rep = 0; rep < 2; rep++) begin
        end_mf(v[3:0]);
        rd(2'd0, d);
        chk("R2 change flag", d[2], (rep == 0 && v[3:0] != prev) ? 1 : 0);
        rd(2'd2, d); chk("R2 rx code", d, {4'd0, v[3:0]});
        rd(2'd2, d); chk("R3 rx code held", d, {4'd0, v[3:0]});
        rd(2'd0, d); chk("R3 change cleared", d[2], 0);
        prev = v[3:0];
      end
    end

    // R4 / R5 ordering
    wr(2'd3, 8'h0A);
    rd(2'd0, d); chk("R4 window before strobe", d[3], 0);
    start_mf();
    chk("R5 written before strobe", txc, 4'hA);
    rd(2'd0, d); chk("R4 window set", d[3], 1);
    wr(2'd3, 8'h05);
    rd(2'd0, d); chk("R4 window cleared by write", d[3], 0);
    chk("R5 written after strobe waits", txc, 4'hA);
    rd(2'd3, d); chk("R9 tx hold readback", d, 8'h05);
    repeat (5) tick();
    chk("R5 steady between strobes", txc, 4'hA);
    start_mf();
    chk("R5 sent at next strobe", txc, 4'h5);
    for (int v = 0; v < 16; v++) begin
      wr(2'd3, {4'd0, v[3:0]});
      chk("R5 sweep before strobe", txc, (v == 0) ? 4'h5 : 4'(v - 1));
      start_mf();
      chk("R5 sweep after strobe", txc, v[3:0]);
    end

    // R7 write colliding with start strobe
    mf_start = 1; req = 1; we = 1; addr = 2'd3; wdata = 8'h09;
    tick();
    rd(2'd0, d); chk("R7 window set wins", d[3], 1);
    chk("R7 strobe took old hold", txc, 4'hF);
    start_mf();
    chk("R7 colliding write sent next", txc, 4'h9);
    wr(2'd3, 8'h09);

    // R7 rx read colliding with a code change (held code is F)
    mf_end = 1; rxc = 4'h4; req = 1; we = 0; addr = 2'd2;
    #1 d = rdata;
    tick();
    chk("R7 read returns old code", d, 8'h0F);
    rd(2'd0, d); chk("R7 change set wins", d[2], 1);
    rd(2'd2, d); chk("R7 new code", d, 8'h04);

    // R7 all four sources in one cycle
    loss = 1; ind = 1; mf_start = 1; mf_end = 1; rxc = 4'h6;
    tick();
    // R6 mask sweep with all status set
    for (int m = 0; m < 16; m++) begin
      wr(2'd1, {4'hF, m[3:0]});
      chk("R6 irq under mask", irq, (m != 15) ? 1 : 0);
    end
    rd(2'd0, d); chk("R7 all recorded, R6 mask keeps status", d, 8'h0F);
    rd(2'd0, d); chk("R8 status read clears bits 1:0", d, 8'h0C);

    // R8 single sources, R6 per-bit enable
    rd(2'd2, d); wr(2'd3, 8'h00);
    rd(2'd0, d); chk("R8 all clear", d, 8'h00);
    wr(2'd1, 8'hFE);
    loss = 1; tick();
    chk("R6 loss enabled irq", irq, 1);
    rd(2'd0, d); chk("R8 loss bit", d, 8'h01);
    chk("R8 loss cleared irq", irq, 0);
    wr(2'd1, 8'hFD);
    ind = 1; tick();
    chk("R6 ind enabled irq", irq, 1);
    wr(2'd1, 8'hFF);
    chk("R6 masked irq low", irq, 0);
    rd(2'd0, d); chk("R8 ind bit", d, 8'h02);
    wr(2'd1, 8'hF7);
    start_mf();
    chk("R6 window enabled irq", irq, 1);
    wr(2'd3, 8'h03);
    chk("R4 write clears window irq", irq, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule